// File: doc/BRIEF.md
# Interleaved Triple-Timer Register Bank

This block is the register front end for three timer channels. A host issues single-cycle read or write strobes with a byte offset and a 32-bit data word. The block decodes the strobe, keeps each channel's configuration, and drives that configuration to an external counter datapath. It also takes back each channel's live count and its interrupt event pulses. The counting logic is not part of this block.

The address map interleaves the channels. Every register kind takes three consecutive 32-bit words, one word per channel. The word index `offset/4` therefore splits into two parts: the kind is `(offset/4)/3` and the channel is `(offset/4) mod 3`. Interrupt status is sticky. It is cleared by reading it, and each channel drives its own interrupt line. A control bit in the counter-control word does not store anything. Instead it produces a one-cycle clear pulse toward that channel's counter.

Top module: `tri_timer_regbank`

## Requirements
- R1: For a word-aligned offset below 0x84, the kind index `(offset/4)/3` selects a register in this order: 0 clock config, 1 counter control, 2 count, 3 interval, 4/5/6 compare A/B/C, 7 interrupt status, 8 interrupt enable, 9 event config, 10 event value. The channel is `(offset/4) mod 3`.
- R2: Writes keep these low bits and drop the rest:
  - 6 bits for clock config, counter control and interrupt enable.
  - 16 bits for interval and the compare registers.
  - 3 bits for event config.
  The stored values appear on the matching channel slice of the configuration outputs.
- R3: A counter-control write with data bit 4 set drives `cnt_clr_o[ch]` high for exactly the cycle after the write. Bit 4 is never stored, so it reads back as 0 and shows as 0 on `cnt_ctrl_o`.
- R4: Reading interrupt status returns the current value and then clears it. A status bit raised through `evt_set_i` in the same cycle as the read survives the clear. Writes to interrupt status are ignored.
- R5: The count kind reads the channel's slice of `cnt_i`, zero-extended from 16 bits. Writes to it change nothing.
- R6: Misaligned offsets and offsets of 0x84 or above read as 0. Writes to them change no register.
- R7: After reset, counter control is 0x21 on every channel, every other register is 0, and `rdata_o` and all interrupt lines are 0.
- R8: `irq_o[ch]` is high exactly when the bitwise AND of that channel's status and enable is nonzero.
- R9: `rdata_o` carries the read result in the cycle after `rd_en_i`. In any cycle not following a read it is 0. A read and a write in the same cycle return the value from before the write.
- R10: The event value kind always reads 0.
- R11: Bits of `evt_set_i` (6 per channel, channel c at bits `[6c+5:6c]`) OR into that channel's status and stay set until a status read of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (12) | Byte offset |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| cnt_i | input | 3*CNT_W (48) | Live count per channel |
| evt_set_i | input | 18 | Status set pulses, 6 per channel |
| clk_cfg_o | output | 18 | Clock config per channel |
| cnt_ctrl_o | output | 18 | Counter control per channel |
| interval_o | output | 3*CNT_W (48) | Interval per channel |
| match_o | output | 9*CNT_W (144) | Compare A/B/C per channel, channel-major |
| int_en_o | output | 18 | Interrupt enable per channel |
| evt_cfg_o | output | 9 | Event config per channel |
| cnt_clr_o | output | 3 | Counter clear pulse per channel |
| irq_o | output | 3 | Interrupt per channel |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a new event pulse on the same channel. The result depends on whether the clear or the set wins. The directed sequence forces this collision on purpose. The random phase also reaches it again and again, because it mixes sparse event pulses with status reads over a dense address range. A second hard case is a misaligned offset that aliases a real register's word. The stimulus sets the low two address bits of mapped offsets to reach it.

// File: rtl/tri_regbank_pkg.sv
package tri_regbank_pkg;
  localparam int NCH       = 3;
  localparam int NUM_MATCH = 3;
  localparam int CFG_W     = 6;
  localparam int EVC_W     = 3;
  localparam int STAT_W    = 6;
  localparam int CLR_BIT   = 4;
  localparam int NUM_WORDS = 33;
  localparam logic [CFG_W-1:0] CTRL_RST = 6'h21;

  typedef enum logic [3:0] {
    K_CLK   = 4'd0,
    K_CTRL  = 4'd1,
    K_COUNT = 4'd2,
    K_INTV  = 4'd3,
    K_M1    = 4'd4,
    K_M2    = 4'd5,
    K_M3    = 4'd6,
    K_STAT  = 4'd7,
    K_IEN   = 4'd8,
    K_EVCFG = 4'd9,
    K_EVVAL = 4'd10
  } kind_e;
endpackage

// File: rtl/tri_regbank_decode.sv
module tri_regbank_decode
  import tri_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output kind_e             kind_o,
  output logic [1:0]        ch_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word, quo, rem;

  always_comb begin
    word   = addr_i[ADDR_W-1:2];
    quo    = word / WORD_W'(NCH);
    rem    = word % WORD_W'(NCH);
    hit_o  = (addr_i[1:0] == 2'b00) && (word < WORD_W'(NUM_WORDS));
    kind_o = kind_e'(quo[3:0]);
    ch_o   = rem[1:0];
  end
endmodule

// File: rtl/tri_regbank_chan.sv
module tri_regbank_chan
  import tri_regbank_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       rd_stat_i,
  input  kind_e                      kind_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [STAT_W-1:0]          set_i,
  output logic [CFG_W-1:0]           clk_cfg_o,
  output logic [CFG_W-1:0]           ctrl_o,
  output logic [CNT_W-1:0]           intv_o,
  output logic [NUM_MATCH*CNT_W-1:0] match_o,
  output logic [STAT_W-1:0]          ien_o,
  output logic [EVC_W-1:0]           evc_o,
  output logic [STAT_W-1:0]          stat_o,
  output logic                       clr_o,
  output logic                       irq_o
);
  localparam logic [CFG_W-1:0] STORE_MASK = ~(CFG_W'(1) << CLR_BIT);

  logic [CFG_W-1:0]  clk_q, ctrl_q;
  logic [CNT_W-1:0]  intv_q;
  logic [STAT_W-1:0] ien_q, stat_q;
  logic [EVC_W-1:0]  evc_q;
  logic              clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q  <= '0;
      ctrl_q <= CTRL_RST;
      intv_q <= '0;
      ien_q  <= '0;
      evc_q  <= '0;
    end else if (wr_i) begin
      case (kind_i)
        K_CLK:   clk_q  <= wdata_i[CFG_W-1:0];
        K_CTRL:  ctrl_q <= wdata_i[CFG_W-1:0] & STORE_MASK;
        K_INTV:  intv_q <= wdata_i[CNT_W-1:0];
        K_IEN:   ien_q  <= wdata_i[STAT_W-1:0];
        K_EVCFG: evc_q  <= wdata_i[EVC_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
    logic [CNT_W-1:0] match_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        match_q <= '0;
      else if (wr_i && (kind_i == kind_e'(4'(K_M1) + 4'(m))))
        match_q <= wdata_i[CNT_W-1:0];
    end
    assign match_o[m*CNT_W +: CNT_W] = match_q;
  end

  // set pulses win over a same-cycle read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      stat_q <= (rd_stat_i ? '0 : stat_q) | set_i;
      clr_q  <= wr_i && (kind_i == K_CTRL) && wdata_i[CLR_BIT];
    end
  end

  assign clk_cfg_o = clk_q;
  assign ctrl_o    = ctrl_q;
  assign intv_o    = intv_q;
  assign ien_o     = ien_q;
  assign evc_o     = evc_q;
  assign stat_o    = stat_q;
  assign clr_o     = clr_q;
  assign irq_o     = |(stat_q & ien_q);
endmodule

// File: rtl/tri_regbank_rdmux.sv
module tri_regbank_rdmux
  import tri_regbank_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                           hit_i,
  input  kind_e                          kind_i,
  input  logic [1:0]                     ch_i,
  input  logic [NCH*CFG_W-1:0]           clk_cfg_i,
  input  logic [NCH*CFG_W-1:0]           ctrl_i,
  input  logic [NCH*CNT_W-1:0]           cnt_i,
  input  logic [NCH*CNT_W-1:0]           intv_i,
  input  logic [NCH*NUM_MATCH*CNT_W-1:0] match_i,
  input  logic [NCH*STAT_W-1:0]          stat_i,
  input  logic [NCH*STAT_W-1:0]          ien_i,
  input  logic [NCH*EVC_W-1:0]           evc_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [1:0] c;

  always_comb begin
    c       = (ch_i < 2'(NCH)) ? ch_i : 2'd0;
    rdata_o = '0;
    if (hit_i) begin
      case (kind_i)
        K_CLK:   rdata_o = DATA_W'(clk_cfg_i[c*CFG_W +: CFG_W]);
        K_CTRL:  rdata_o = DATA_W'(ctrl_i[c*CFG_W +: CFG_W]);
        K_COUNT: rdata_o = DATA_W'(cnt_i[c*CNT_W +: CNT_W]);
        K_INTV:  rdata_o = DATA_W'(intv_i[c*CNT_W +: CNT_W]);
        K_M1:    rdata_o = DATA_W'(match_i[(c*NUM_MATCH+0)*CNT_W +: CNT_W]);
        K_M2:    rdata_o = DATA_W'(match_i[(c*NUM_MATCH+1)*CNT_W +: CNT_W]);
        K_M3:    rdata_o = DATA_W'(match_i[(c*NUM_MATCH+2)*CNT_W +: CNT_W]);
        K_STAT:  rdata_o = DATA_W'(stat_i[c*STAT_W +: STAT_W]);
        K_IEN:   rdata_o = DATA_W'(ien_i[c*STAT_W +: STAT_W]);
        K_EVCFG: rdata_o = DATA_W'(evc_i[c*EVC_W +: EVC_W]);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tri_timer_regbank.sv
module tri_timer_regbank
  import tri_regbank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic [NCH*CNT_W-1:0]           cnt_i,
  input  logic [NCH*STAT_W-1:0]          evt_set_i,
  output logic [NCH*CFG_W-1:0]           clk_cfg_o,
  output logic [NCH*CFG_W-1:0]           cnt_ctrl_o,
  output logic [NCH*CNT_W-1:0]           interval_o,
  output logic [NCH*NUM_MATCH*CNT_W-1:0] match_o,
  output logic [NCH*STAT_W-1:0]          int_en_o,
  output logic [NCH*EVC_W-1:0]           evt_cfg_o,
  output logic [NCH-1:0]                 cnt_clr_o,
  output logic [NCH-1:0]                 irq_o
);
  logic              hit;
  kind_e             kind;
  logic [1:0]        ch;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic [NCH*STAT_W-1:0] stat_all;

  tri_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .kind_o (kind),
    .ch_o   (ch)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = hit && (ch == 2'(c));

    tri_regbank_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i && sel),
      .rd_stat_i (rd_en_i && sel && (kind == K_STAT)),
      .kind_i    (kind),
      .wdata_i   (wdata_i),
      .set_i     (evt_set_i[c*STAT_W +: STAT_W]),
      .clk_cfg_o (clk_cfg_o[c*CFG_W +: CFG_W]),
      .ctrl_o    (cnt_ctrl_o[c*CFG_W +: CFG_W]),
      .intv_o    (interval_o[c*CNT_W +: CNT_W]),
      .match_o   (match_o[c*NUM_MATCH*CNT_W +: NUM_MATCH*CNT_W]),
      .ien_o     (int_en_o[c*STAT_W +: STAT_W]),
      .evc_o     (evt_cfg_o[c*EVC_W +: EVC_W]),
      .stat_o    (stat_all[c*STAT_W +: STAT_W]),
      .clr_o     (cnt_clr_o[c]),
      .irq_o     (irq_o[c])
    );
  end

  tri_regbank_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rdmux (
    .hit_i     (hit),
    .kind_i    (kind),
    .ch_i      (ch),
    .clk_cfg_i (clk_cfg_o),
    .ctrl_i    (cnt_ctrl_o),
    .cnt_i     (cnt_i),
    .intv_i    (interval_o),
    .match_i   (match_o),
    .stat_i    (stat_all),
    .ien_i     (int_en_o),
    .evc_i     (evt_cfg_o),
    .rdata_o   (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tri_regbank_chk.sv
module tri_regbank_chk
  import tri_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_en_i,
  input logic                  wr_en_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [NCH*CFG_W-1:0]  cnt_ctrl_o,
  input logic [NCH*STAT_W-1:0] int_en_o,
  input logic [NCH*STAT_W-1:0] stat_i,
  input logic [NCH-1:0]        cnt_clr_o,
  input logic [NCH-1:0]        irq_o
);
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> (rdata_o == '0));

  a_r3_clr_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cnt_clr_o) |-> $past(wr_en_i));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r3_bit_unstored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_ctrl_o[c*CFG_W+CLR_BIT] == 1'b0);

    a_r8_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (|int_en_o[c*STAT_W +: STAT_W]));

    a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|stat_i[c*STAT_W +: STAT_W]) && !rd_en_i) |=> (|stat_i[c*STAT_W +: STAT_W]));
  end
endmodule

bind tri_timer_regbank tri_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .rdata_o    (rdata_o),
  .cnt_ctrl_o (cnt_ctrl_o),
  .int_en_o   (int_en_o),
  .stat_i     (stat_all),
  .cnt_clr_o  (cnt_clr_o),
  .irq_o      (irq_o)
);

// File: tb/tri_timer_regbank_tb_top.sv
module tri_timer_regbank_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0]  addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [47:0]  cnt_i = '0;
  logic [17:0]  evt_set_i = '0;
  logic [17:0]  clk_cfg_o, cnt_ctrl_o, int_en_o;
  logic [47:0]  interval_o;
  logic [143:0] match_o;
  logic [8:0]   evt_cfg_o;
  logic [2:0]   cnt_clr_o, irq_o;

  always #5 clk_i = ~clk_i;

  tri_timer_regbank dut_i (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [5:0]  m_clk[3], m_ctrl[3], m_stat[3], m_ien[3];
  logic [15:0] m_intv[3], m_cnt[3];
  logic [15:0] m_match[3][3];
  logic [2:0]  m_evc[3];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w, c, k;
    w = int'(a[11:2]);
    if (a[1:0] != 2'b00 || w >= 33) return 32'h0;
    c = w % 3; k = w / 3;
    case (k)
      0: return {26'h0, m_clk[c]};
      1: return {26'h0, m_ctrl[c]};
      2: return {16'h0, m_cnt[c]};
      3: return {16'h0, m_intv[c]};
      4, 5, 6: return {16'h0, m_match[c][k-4]};
      7: return {26'h0, m_stat[c]};
      8: return {26'h0, m_ien[c]};
      9: return {29'h0, m_evc[c]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    int w;
    w = int'(a[11:2]);
    if (a[1:0] != 2'b00 || w >= 33) return "R6";
    case (w / 3)
      2: return "R5";
      7: return "R4";
      10: return "R10";
      default: return "R1";
    endcase
  endfunction

  // one bus cycle: drive at negedge, update model, check after posedge
  task automatic cyc(input bit we, input bit re, input logic [11:0] a,
                     input logic [31:0] d, input logic [17:0] set);
    logic [31:0] e_rd;
    logic [2:0]  e_clr;
    logic [2:0]  e_irq;
    int w, c, k;
    bit ok;
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) m_cnt[i] = 16'($urandom);
    cnt_i = {m_cnt[2], m_cnt[1], m_cnt[0]};
    wr_en_i = we; rd_en_i = re; addr_i = a; wdata_i = d; evt_set_i = set;
    e_rd = re ? exp_read(a) : 32'h0;
    e_clr = '0;
    w = int'(a[11:2]); c = w % 3; k = w / 3;
    for (int i = 0; i < 3; i++) begin
      if (re && a[1:0] == 2'b00 && w < 33 && k == 7 && c == i) m_stat[i] = set[i*6 +: 6];
      else m_stat[i] = m_stat[i] | set[i*6 +: 6];
    end
    if (we && a[1:0] == 2'b00 && w < 33) begin
      case (k)
        0: m_clk[c] = d[5:0];
        1: begin m_ctrl[c] = d[5:0] & 6'h2F; e_clr[c] = d[4]; end
        3: m_intv[c] = d[15:0];
        4, 5, 6: m_match[c][k-4] = d[15:0];
        8: m_ien[c] = d[5:0];
        9: m_evc[c] = d[2:0];
        default: ;
      endcase
    end
    for (int i = 0; i < 3; i++) e_irq[i] = |(m_stat[i] & m_ien[i]);
    @(posedge clk_i);
    #2;
    if (re) chk(rdata_o == e_rd, $sformatf("%s/R9 read %0h", tag_of(a), a), rdata_o, e_rd);
    else chk(rdata_o == 32'h0, "R9 idle", rdata_o, 0);
    chk(cnt_clr_o == e_clr, "R3 clear pulse", cnt_clr_o, e_clr);
    chk(irq_o == e_irq, "R8 irq", irq_o, e_irq);
    ok = 1;
    for (int i = 0; i < 3; i++) begin
      if (clk_cfg_o[i*6 +: 6] != m_clk[i] || cnt_ctrl_o[i*6 +: 6] != m_ctrl[i]) ok = 0;
      if (int_en_o[i*6 +: 6] != m_ien[i] || evt_cfg_o[i*3 +: 3] != m_evc[i]) ok = 0;
      if (interval_o[i*16 +: 16] != m_intv[i]) ok = 0;
      for (int j = 0; j < 3; j++) if (match_o[(i*3+j)*16 +: 16] != m_match[i][j]) ok = 0;
    end
    chk(ok, "R2 config outputs", cnt_ctrl_o, {m_ctrl[2], m_ctrl[1], m_ctrl[0]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) begin
      m_clk[i] = 0; m_ctrl[i] = 6'h21; m_stat[i] = 0; m_ien[i] = 0;
      m_intv[i] = 0; m_evc[i] = 0; m_cnt[i] = 0;
      for (int j = 0; j < 3; j++) m_match[i][j] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk(cnt_ctrl_o == {3{6'h21}}, "R7 ctrl reset", cnt_ctrl_o, {3{6'h21}});
    chk(rdata_o == 0 && irq_o == 0 && cnt_clr_o == 0, "R7 outputs reset", {rdata_o, irq_o}, 0);
    rst_ni = 1'b1;
    // R7: every mapped word reads its reset value
    for (int w = 0; w < 33; w++) cyc(0, 1, 12'(w * 4), 0, 0);
    // R2: masks
    cyc(1, 0, 12'h004, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 12'h028, 32'hABCD_1234, 0);
    cyc(1, 0, 12'h050, 32'h5555_BEEF, 0);
    cyc(1, 0, 12'h074, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 12'h004, 0, 0);
    cyc(0, 1, 12'h028, 0, 0);
    chk(rdata_o == 32'h1234, "R2 interval mask", rdata_o, 32'h1234);
    cyc(0, 1, 12'h074, 0, 0);
    chk(rdata_o == 32'h7, "R2 event config mask", rdata_o, 32'h7);
    // R3: clear bit pulses, not stored
    cyc(1, 0, 12'h010, 32'h0000_003F, 0);
    chk(cnt_clr_o == 3'b010, "R3 pulse on ch1", cnt_clr_o, 3'b010);
    cyc(0, 1, 12'h010, 0, 0);
    chk(rdata_o == 32'h2F && cnt_clr_o == 0, "R3 bit reads 0", rdata_o, 32'h2F);
    // R5: count write ignored
    cyc(1, 1, 12'h01C, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 12'h01C, 0, 0);
    // R10: event value reads 0
    cyc(1, 1, 12'h080, 32'hFFFF_FFFF, 0);
    chk(rdata_o == 0, "R10 event value", rdata_o, 0);
    // R6: unmapped and misaligned
    cyc(1, 0, 12'h00D, 32'h0000_0000, 0);
    cyc(1, 0, 12'h084, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 12'h00C, 0, 0);
    chk(rdata_o == 32'h21, "R6 misaligned write ignored", rdata_o, 32'h21);
    cyc(0, 1, 12'h085, 0, 0);
    cyc(0, 1, 12'hFFC, 0, 0);
    cyc(0, 1, 12'h001, 0, 0);
    // R4/R8/R11: sticky status, clear-on-read, collision
    cyc(1, 0, 12'h064, 32'h3F, 0);
    cyc(0, 0, 0, 0, 18'h05 << 6);
    chk(irq_o == 3'b010, "R8 irq ch1 high", irq_o, 3'b010);
    cyc(0, 0, 0, 0, 18'h08 << 6);
    cyc(1, 0, 12'h058, 32'h0, 0);
    cyc(0, 1, 12'h058, 0, 18'h02 << 6);
    chk(rdata_o == 32'h0D, "R4 read returns value", rdata_o, 32'h0D);
    cyc(0, 1, 12'h058, 0, 0);
    chk(rdata_o == 32'h02, "R4 set wins over clear", rdata_o, 32'h02);
    cyc(0, 1, 12'h058, 0, 0);
    chk(rdata_o == 0 && irq_o == 0, "R4 cleared", rdata_o, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [17:0] s;
      if ($urandom_range(0, 15) == 0) a = 12'($urandom_range(0, 255));
      else a = 12'($urandom_range(0, 37) * 4);
      s = ($urandom_range(0, 7) == 0) ? 18'($urandom) : 18'h0;
      cyc(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), a, $urandom, s);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule